// File: doc/BRIEF.md
# Programmable Interrupt Interval Timer

A 16-bit down-counting interval timer driven by a clock enable that fires on every second system clock. A power-of-two prescaler, selectable from 1 to 32768, turns that enable into count ticks. Each tick moves the counter down by one. When the counter lands on zero, an interrupt flag is raised. A level interrupt request follows the flag whenever the interrupt-enable bit is set.

Two modes are available. In reload mode, the counter is refilled from a modulus latch on the tick after it reaches zero. This gives a timeout of 2^PRE x (PM + 1) half-clock periods. In free-running mode, the counter wraps to all ones and keeps going. An overwrite option lets a modulus write load the counter at once, so software need not wait for the current period to end.

Software uses a small register port: a write strobe, a 2-bit register select, write data, and combinational read data. The flag is cleared by writing a 1 to its bit.

Top module: `iit_timer`

## Requirements
- R1: After reset, the control register reads 0x0000, the modulus and count registers read 0xFFFF, and `irq` is low.
- R2: Select 0 is control. Its bit 0 is run, bit 1 is reload select, bit 2 is the flag (write 1 to clear), bit 3 is interrupt enable, bit 4 is overwrite, and bits 11:8 are PRE. Select 1 is the modulus, read/write. Select 2 is the count, read-only: writes to it are ignored. Select 3 reads 0.
- R3: With reload select set, the flag sets once every 2^(PRE+1) x (PM+1) system clocks, because each prescaled tick spans 2^PRE half-clock enables.
- R4: With reload select clear, a tick at count 0 produces 0xFFFF, and the tick after that produces 0xFFFE.
- R5: The flag sets in the cycle the count becomes 0x0000, in both modes.
- R6: `irq` is high exactly when the flag is set and interrupt enable is 1. With interrupt enable at 0, the flag still reads back as set.
- R7: Writing 1 to bit 2 of control clears the flag and drops `irq`. Writing 0 there leaves the flag unchanged.
- R8: If the flag is set and cleared in the same cycle, the set wins.
- R9: With overwrite at 1, a modulus write loads the count register by the next cycle.
- R10: With overwrite at 0, a modulus write changes only the latch, and the count keeps its value.
- R11: With run at 0, the count holds its value.
- R12: Writing run from 0 to 1 loads the count from the modulus latch and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench measures the spacing of interrupt edges over a table of prescaler and modulus pairs. This includes a zero modulus and a large prescaler. An off-by-one in the reload, or a prescaler counting to 2^PRE instead of 2^PRE - 1, shows up as a wrong period.

It places a flag clear on the exact cycle of a new set. A design that lets the clear win would show `irq` low there.

Further tests cover the following cases:
- Reading the count around zero in free-running mode. A design that reloaded there would show the modulus instead of 0xFFFF.
- A modulus write with overwrite set and with overwrite clear. A swapped decode would either leave the count unchanged or corrupt it.
- Disabling the timer, with and without a later re-enable. A design that kept counting while stopped, or that failed to reload on restart, would read back a changed count.

// File: rtl/iit_pkg.sv
package iit_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  localparam int B_RUN  = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLG  = 2;
  localparam int B_IE   = 3;
  localparam int B_OW   = 4;
  localparam int B_PRE  = 8;
endpackage

// File: rtl/iit_halfclk.sv
module iit_halfclk (
  input  logic clk,
  input  logic rst_n,
  output logic hclk_en
);
  logic ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ~ph_q;
  end

  assign hclk_en = ph_q;
endmodule

// File: rtl/iit_prescaler.sv
module iit_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             hclk_en,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PSC_W = (1 << PRE_W) - 1;

  logic [PSC_W-1:0] psc_q;
  logic             at_lim;

  // terminal value of the divider: 2^p - 1
  function automatic logic [PSC_W-1:0] div_limit(input logic [PRE_W-1:0] p);
    logic [PSC_W:0] t;
    t = ({{PSC_W{1'b0}}, 1'b1} << p) - 1'b1;
    return t[PSC_W-1:0];
  endfunction

  assign at_lim = (psc_q >= div_limit(pre));
  assign tick   = run && hclk_en && at_lim && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                psc_q <= '0;
    else if (restart)          psc_q <= '0;
    else if (run && hclk_en)   psc_q <= at_lim ? '0 : psc_q + 1'b1;
  end
endmodule

// File: rtl/iit_counter.sv
module iit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             rld,
  input  logic [CNT_W-1:0] mod,
  output logic [CNT_W-1:0] cnt,
  output logic             set_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;

  // value after one tick: decrement, or at zero reload / wrap
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] modv,
    input logic             rl
  );
    if (cur == '0) return rl ? modv : '1;
    return cur - 1'b1;
  endfunction

  assign nxt     = next_count(cnt_q, mod, rld);
  assign set_evt = tick && !load && (nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '1;
    else if (load)  cnt_q <= load_val;
    else if (tick)  cnt_q <= nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/iit_regs.sv
module iit_regs
  import iit_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] wdata,
  input  logic             set_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic             en,
  output logic             rld,
  output logic             ie,
  output logic             ow,
  output logic [PRE_W-1:0] pre,
  output logic [CNT_W-1:0] mod,
  output logic             flag,
  output logic             en_rise,
  output logic             ow_load,
  output logic [CNT_W-1:0] rdata
);
  logic             wr_ctl, wr_mod, clr;
  logic             en_q, rld_q, ie_q, ow_q, flag_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] mod_q;

  assign wr_ctl  = wr && (sel == SEL_CTRL);
  assign wr_mod  = wr && (sel == SEL_MOD);
  assign clr     = wr_ctl && wdata[B_FLG];
  assign en_rise = wr_ctl && wdata[B_RUN] && !en_q;
  assign ow_load = wr_mod && ow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rld_q <= 1'b0;
      ie_q  <= 1'b0;
      ow_q  <= 1'b0;
      pre_q <= '0;
    end else if (wr_ctl) begin
      en_q  <= wdata[B_RUN];
      rld_q <= wdata[B_RLD];
      ie_q  <= wdata[B_IE];
      ow_q  <= wdata[B_OW];
      pre_q <= wdata[B_PRE +: PRE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mod_q <= '1;
    else if (wr_mod) mod_q <= wdata;
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    unique case (sel_e'(sel))
      SEL_CTRL: begin
        rdata[B_RUN]             = en_q;
        rdata[B_RLD]             = rld_q;
        rdata[B_FLG]             = flag_q;
        rdata[B_IE]              = ie_q;
        rdata[B_OW]              = ow_q;
        rdata[B_PRE +: PRE_W]    = pre_q;
      end
      SEL_MOD:  rdata = mod_q;
      SEL_CNT:  rdata = cnt;
      SEL_NONE: rdata = '0;
    endcase
  end

  assign en   = en_q;
  assign rld  = rld_q;
  assign ie   = ie_q;
  assign ow   = ow_q;
  assign pre  = pre_q;
  assign mod  = mod_q;
  assign flag = flag_q;
endmodule

// File: rtl/iit_timer.sv
module iit_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  logic             hclk_en, tick, set_evt;
  logic             en_q, rld_q, ie_q, ow_q, flag_q;
  logic             en_rise, ow_load, cnt_load;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] mod_q, cnt_q, load_val;

  iit_halfclk u_half (
    .clk     (clk),
    .rst_n   (rst_n),
    .hclk_en (hclk_en)
  );

  iit_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .set_evt (set_evt),
    .cnt     (cnt_q),
    .en      (en_q),
    .rld     (rld_q),
    .ie      (ie_q),
    .ow      (ow_q),
    .pre     (pre_q),
    .mod     (mod_q),
    .flag    (flag_q),
    .en_rise (en_rise),
    .ow_load (ow_load),
    .rdata   (reg_rdata)
  );

  assign cnt_load = en_rise || ow_load;
  assign load_val = ow_load ? reg_wdata : mod_q;

  iit_prescaler #(.PRE_W(PRE_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_q),
    .restart (cnt_load),
    .hclk_en (hclk_en),
    .pre     (pre_q),
    .tick    (tick)
  );

  iit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (cnt_load),
    .load_val (load_val),
    .rld      (rld_q),
    .mod      (mod_q),
    .cnt      (cnt_q),
    .set_evt  (set_evt)
  );

  assign irq = flag_q && ie_q;
endmodule

// File: rtl/iit_timer_chk.sv
module iit_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             irq,
  input logic             en_q,
  input logic             rld_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] mod_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             tick,
  input logic             set_evt,
  input logic             en_rise,
  input logic             ow_load
);
  logic clr_wr;
  assign clr_wr = reg_wr && (reg_sel == 2'd0) && reg_wdata[2];

  p_tick_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt_q != '0) && !ow_load |=> cnt_q == $past(cnt_q) - 1'b1);

  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt_q == '0) && rld_q && !ow_load |=> cnt_q == $past(mod_q));

  p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cnt_q == '0) && !rld_q && !ow_load |=> cnt_q == '1);

  p_flag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q && (cnt_q == '0));

  p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt && ie_q && !(reg_wr && reg_sel == 2'd0) |=> irq);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !set_evt |=> !irq);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && set_evt |=> flag_q);

  p_ow_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ow_load |=> cnt_q == $past(reg_wdata));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !en_rise && !ow_load |=> $stable(cnt_q));

  p_en_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> cnt_q == $past(mod_q));
endmodule

bind iit_timer iit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .en_q      (en_q),
  .rld_q     (rld_q),
  .ie_q      (ie_q),
  .flag_q    (flag_q),
  .mod_q     (mod_q),
  .cnt_q     (cnt_q),
  .tick      (tick),
  .set_evt   (set_evt),
  .en_rise   (en_rise),
  .ow_load   (ow_load)
);

// File: tb/test_iit_timer.sv
module test_iit_timer;
  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 150000;

  typedef struct packed {
    logic [3:0]  pre;
    logic [15:0] pm;
    logic [19:0] per;
  } vec_t;

  // prescale, modulus, expected clocks between interrupts
  localparam vec_t VEC [0:6] = '{
    '{pre: 4'd0,  pm: 16'd1, per: 20'd4},
    '{pre: 4'd0,  pm: 16'd5, per: 20'd12},
    '{pre: 4'd1,  pm: 16'd3, per: 20'd16},
    '{pre: 4'd2,  pm: 16'd2, per: 20'd24},
    '{pre: 4'd3,  pm: 16'd0, per: 20'd16},
    '{pre: 4'd4,  pm: 16'd7, per: 20'd256},
    '{pre: 4'd10, pm: 16'd1, per: 20'd4096}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  iit_timer i_iit_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] cfg(input bit run, input bit rl, input bit ie,
                                      input bit ow, input bit fc, input logic [3:0] pre);
    logic [15:0] v;
    v = '0;
    v[0] = run; v[1] = rl; v[2] = fc; v[3] = ie; v[4] = ow;
    v[11:8] = pre;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq(output int t);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 20000);
    if (!irq) chk("R5 irq timeout", 0, 1);
    t = cyc;
  endtask

  initial begin
    #(CLK_PER * WD_CYC);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c1;
    int t0, t1;

    repeat (3) @(negedge clk);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 mod", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 cnt", v, 16'hFFFF);
    chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl after release", v, 16'h0000);

    // R3 / R2 period table
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, cfg(0, 1, 1, 0, 1, VEC[i].pre));
      wr(2'd1, VEC[i].pm);
      wr(2'd0, cfg(1, 1, 1, 0, 0, VEC[i].pre));
      wait_irq(t0);
      wr(2'd0, cfg(1, 1, 1, 0, 1, VEC[i].pre));
      wait_irq(t1);
      chk($sformatf("R3 period vec %0d", i), t1 - t0, VEC[i].per);
    end

    // R7 / R8: clear, then clear on the exact set cycle (pm=1, pre=0)
    wr(2'd0, cfg(0, 1, 1, 0, 1, 4'd0));
    wr(2'd1, 16'd1);
    wr(2'd0, cfg(1, 1, 1, 0, 0, 4'd0));
    wait_irq(t0);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = cfg(1, 1, 1, 0, 1, 4'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 clear drops irq", irq, 0);
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = cfg(1, 1, 1, 0, 1, 4'd0);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 set beats clear", irq, 1);

    // R7 writing 0 to the flag bit keeps it; R6 gating
    wr(2'd0, cfg(0, 1, 1, 0, 0, 4'd0));
    chk("R7 zero write keeps flag", irq, 1);
    wr(2'd0, cfg(0, 1, 0, 0, 0, 4'd0));
    chk("R6 irq masked", irq, 0);
    rd(2'd0, v); chk("R6 flag still set", v[2], 1);
    wr(2'd0, cfg(0, 1, 1, 0, 0, 4'd0));
    chk("R6 irq unmasked", irq, 1);

    // R4 / R5 free-running wrap
    wr(2'd0, cfg(0, 0, 1, 0, 1, 4'd0));
    wr(2'd1, 16'd3);
    wr(2'd0, cfg(1, 0, 1, 0, 0, 4'd0));
    wait_irq(t0);
    rd(2'd2, v); chk("R5 count zero at flag", v, 16'h0000);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); chk("R4 wrap to all ones", v, 16'hFFFF);
    @(negedge clk); @(negedge clk);
    rd(2'd2, v); chk("R4 keeps counting", v, 16'hFFFE);

    // R12 enable load, R9 overwrite, R10 latch only, R2 map
    wr(2'd0, cfg(0, 1, 0, 1, 1, 4'd15));
    wr(2'd0, cfg(1, 1, 0, 1, 0, 4'd15));
    rd(2'd2, v); chk("R12 enable loads modulus", v, 16'd3);
    wr(2'd1, 16'h1234);
    rd(2'd2, v); chk("R9 overwrite loads count", v, 16'h1234);
    wr(2'd0, cfg(1, 1, 0, 0, 0, 4'd15));
    wr(2'd1, 16'h5555);
    rd(2'd2, v); chk("R10 count unchanged", v, 16'h1234);
    rd(2'd1, v); chk("R10 latch updated", v, 16'h5555);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R2 count write ignored", v, 16'h1234);
    rd(2'd3, v); chk("R2 unused select", v, 16'h0000);

    // R11 hold while stopped, R12 reload on restart
    wr(2'd0, cfg(0, 1, 0, 0, 0, 4'd0));
    wr(2'd0, cfg(1, 1, 0, 0, 0, 4'd0));
    repeat (20) @(negedge clk);
    wr(2'd0, cfg(0, 1, 0, 0, 0, 4'd0));
    rd(2'd2, c1);
    chk("R2 counted while running", c1 != 16'h5555, 1);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R11 count held", v, c1);
    wr(2'd0, cfg(1, 1, 0, 0, 0, 4'd0));
    rd(2'd2, v); chk("R12 restart reloads", v, 16'h5555);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule